// File: doc/BRIEF.md
# FSK Transponder Bit Demodulator

This block recovers a low-frequency transponder's reply from a single-bit zero-crossing comparator stream, taking one sample on every clock at 2 MHz. It counts the rising crossings, and after every sixteen carrier cycles it measures how many samples those cycles took. The slower carrier (about 123 kHz) gives a count near 259 and is read as a 1. The faster carrier (about 134 kHz) gives a count near 238 and is read as a 0. Any other count is treated as noise and discards everything gathered so far.

Recovered bits arrive least significant bit first. They enter a 128-bit frame register at its top end and shift towards bit 0. After each new bit the block looks for a frame in the register. A frame needs a sync pattern in the low bits and a trailing byte equal to the leading byte. When a frame is found, the block publishes the 64-bit payload, the 16-bit check field (which it does not verify), a rewritable flag and an ident-mismatch flag, all with a one-cycle strobe.

Top module: `fsk_tag_demod`

## Requirements
- R1: A carrier cycle is counted on each clock where `zc_i` is 1 and was 0 on the previous clock. Every 16th counted cycle is a measurement point.
- R2: The value measured at a measurement point is the number of samples since the previous measurement point. The count saturates at 2^CNT_W-1 (511 by default) and does not wrap.
- R3: A measured value strictly between 248 and 270 yields bit 1. A value strictly between 227 and 249 yields bit 0.
- R4: A measured value outside both ranges clears all 128 bits of the frame register and adds no bit.
- R5: Each new bit is written into register bit 127 while the register shifts right by one, so the first bit received ends up lowest.
- R6: A frame is accepted after a new bit when register bits [22:0] equal 23'h7E0000 and register bits [23:16] equal bits [111:104]. Otherwise nothing is published.
- R7: On acceptance, `data_o` is register bits [87:24], `crc_o` is bits [103:88] and `rw_o` is bit 111.
- R8: `ident_err_o` is 1 on acceptance only when bit 111 is 1 and register bits [126:112] differ from `data_o[14:0]`. It is 0 for a read-only frame.
- R9: `frame_valid_o` is high for exactly one cycle per accepted frame. All other outputs keep their values until the next accepted frame.
- R10: While `rst_n` is low at a clock edge, all counters, the frame register and all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one comparator sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_i | input | 1 | Zero-crossing comparator sample (1 = positive) |
| frame_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| data_o | output | 64 | Payload of the last accepted frame |
| crc_o | output | 16 | Check field of the last accepted frame |
| rw_o | output | 1 | Last accepted frame came from a rewritable tag |
| ident_err_o | output | 1 | Rewritable frame whose ident differs from the payload |

## Verification
The assertions check, on every cycle, the per-bit behaviour. A measurement inside the 1 range lands as a 1 in bit 127. A 0 measurement shifts the register right. A noise measurement empties the register. They also check that the strobe lasts one cycle, that outputs hold between frames and that the published fields match the register as it stood. Only the bench's scenarios can show the end-to-end decode of whole frames: a rewritable frame with a matching ident, a read-only frame, an ident mismatch, a frame rejected because its trailing byte differs, and a long silent gap whose saturated count must act as noise rather than wrap into a valid bit.

// File: rtl/fskd_pkg.sv
// fskd_pkg: frame field positions and shared constant functions for the
// FSK transponder demodulator. Field positions are fixed by the frame
// layout; only the timing constants are parameters of the modules.
package fskd_pkg;

    localparam int FRAME_W   = 128;
    localparam int SYNC_W    = 23;
    localparam logic [SYNC_W-1:0] SYNC_VAL = 23'h7E0000;
    localparam int START_LSB = 16;
    localparam int END_LSB   = 104;
    localparam int DATA_LSB  = 24;
    localparam int DATA_W    = 64;
    localparam int CRC_LSB   = 88;
    localparam int CRC_W     = 16;
    localparam int RW_BIT    = 111;
    localparam int IDENT_LSB = 112;
    localparam int IDENT_W   = 15;

    // Samples taken by a group of carrier cycles, truncated.
    function automatic longint span_samples(longint fs_hz, longint f_hz, longint cycles);
        return (fs_hz * cycles) / f_hz;
    endfunction

endpackage

// File: rtl/fskd_period_meter.sv
// fskd_period_meter: detects rising crossings of the comparator sample and,
// every CYC_PER_BIT crossings, reports the samples elapsed since the last
// report. Assumes one sample per clock; the sample count saturates.
module fskd_period_meter #(
    parameter int CYC_PER_BIT = 16,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] period_o
);
    localparam int EC_W = $clog2(CYC_PER_BIT);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [EC_W-1:0]  EC_LAST = EC_W'(CYC_PER_BIT - 1);

    logic             zc_q;
    logic [EC_W-1:0]  edge_cnt;
    logic [CNT_W-1:0] smp_cnt;
    logic             rise;
    logic             group_end;

    assign rise      = zc_i & ~zc_q;
    assign group_end = rise && (edge_cnt == EC_LAST);

    // Track previous sample, cycle count and saturating sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_q         <= 1'b0;
            edge_cnt     <= '0;
            smp_cnt      <= '0;
            meas_valid_o <= 1'b0;
            period_o     <= '0;
        end else begin
            zc_q         <= zc_i;
            meas_valid_o <= group_end;
            if (rise)
                edge_cnt <= group_end ? '0 : edge_cnt + 1'b1;
            if (group_end) begin
                period_o <= smp_cnt;
                smp_cnt  <= CNT_W'(1);
            end else if (smp_cnt != CNT_MAX) begin
                smp_cnt <= smp_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fskd_classifier.sv
// fskd_classifier: maps a measured period onto bit 1, bit 0 or noise using
// two open tolerance windows derived from the carrier frequencies.
// Purely combinational; assumes at most one measurement per cycle.
module fskd_classifier #(
    parameter longint SAMPLE_HZ   = 2_000_000,
    parameter longint F_ONE_HZ    = 123_200,
    parameter longint F_ZERO_HZ   = 134_200,
    parameter int     CYC_PER_BIT = 16,
    parameter int     CNT_W       = 9
) (
    input  logic             meas_valid_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             bit_valid_o,
    output logic             bit_o,
    output logic             noise_o
);
    localparam longint EXP_ONE  = fskd_pkg::span_samples(SAMPLE_HZ, F_ONE_HZ, CYC_PER_BIT);
    localparam longint EXP_ZERO = fskd_pkg::span_samples(SAMPLE_HZ, F_ZERO_HZ, CYC_PER_BIT);
    localparam longint TOL      = (EXP_ONE - EXP_ZERO + 1) >>> 1;
    localparam logic [CNT_W:0] ONE_LO  = (CNT_W+1)'(EXP_ONE - TOL);
    localparam logic [CNT_W:0] ONE_HI  = (CNT_W+1)'(EXP_ONE + TOL);
    localparam logic [CNT_W:0] ZERO_LO = (CNT_W+1)'(EXP_ZERO - TOL);
    localparam logic [CNT_W:0] ZERO_HI = (CNT_W+1)'(EXP_ZERO + TOL);

    logic [CNT_W:0] p;
    logic           in_one;
    logic           in_zero;

    // Window tests, the 1 window taking priority.
    always_comb begin
        p           = {1'b0, period_i};
        in_one      = (p > ONE_LO) && (p < ONE_HI);
        in_zero     = (p > ZERO_LO) && (p < ZERO_HI);
        bit_valid_o = meas_valid_i && (in_one || in_zero);
        bit_o       = in_one;
        noise_o     = meas_valid_i && !(in_one || in_zero);
    end

endmodule

// File: rtl/fskd_frame_shift.sv
// fskd_frame_shift: 128-bit right-shifting frame register. New bits enter
// at the top; a noise indication empties it. Flags each shifted bit one
// cycle later so the detector sees the updated register.
module fskd_frame_shift (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_i,
    input  logic                          bit_i,
    input  logic                          clear_i,
    output logic [fskd_pkg::FRAME_W-1:0]  shreg_o,
    output logic                          new_bit_o
);
    // Shift, clear or hold the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_o   <= '0;
            new_bit_o <= 1'b0;
        end else begin
            new_bit_o <= shift_i;
            if (clear_i)
                shreg_o <= '0;
            else if (shift_i)
                shreg_o <= {bit_i, shreg_o[fskd_pkg::FRAME_W-1:1]};
        end
    end

endmodule

// File: rtl/fskd_frame_detect.sv
// fskd_frame_detect: after each new bit, tests the frame register for the
// sync pattern and matching leading/trailing bytes, then latches the
// payload fields and raises a one-cycle strobe. Fields hold otherwise.
module fskd_frame_detect
    import fskd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check_i,
    input  logic [FRAME_W-1:0] shreg_i,
    output logic               frame_valid_o,
    output logic [DATA_W-1:0]  data_o,
    output logic [CRC_W-1:0]   crc_o,
    output logic               rw_o,
    output logic               ident_err_o
);
    logic              hit;
    logic [DATA_W-1:0] data_f;
    logic              rw_f;

    // Candidate and acceptance tests on the current register.
    always_comb begin
        data_f = shreg_i[DATA_LSB +: DATA_W];
        rw_f   = shreg_i[RW_BIT];
        hit    = (shreg_i[SYNC_W-1:0] == SYNC_VAL) &&
                 (shreg_i[START_LSB +: 8] == shreg_i[END_LSB +: 8]);
    end

    // Latch fields and pulse the strobe on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid_o <= 1'b0;
            data_o        <= '0;
            crc_o         <= '0;
            rw_o          <= 1'b0;
            ident_err_o   <= 1'b0;
        end else begin
            frame_valid_o <= check_i && hit;
            if (check_i && hit) begin
                data_o      <= data_f;
                crc_o       <= shreg_i[CRC_LSB +: CRC_W];
                rw_o        <= rw_f;
                ident_err_o <= rw_f && (shreg_i[IDENT_LSB +: IDENT_W] != data_f[IDENT_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/fsk_tag_demod.sv
// fsk_tag_demod: top level of the FSK transponder demodulator. Chain:
// period meter -> classifier -> frame register -> frame detector.
// Assumes zc_i is already synchronous to clk, one sample per cycle.
module fsk_tag_demod #(
    parameter longint SAMPLE_HZ   = 2_000_000,
    parameter longint F_ONE_HZ    = 123_200,
    parameter longint F_ZERO_HZ   = 134_200,
    parameter int     CYC_PER_BIT = 16,
    parameter int     CNT_W       = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        zc_i,
    output logic        frame_valid_o,
    output logic [63:0] data_o,
    output logic [15:0] crc_o,
    output logic        rw_o,
    output logic        ident_err_o
);
    logic                         meas_valid;
    logic [CNT_W-1:0]             meas_period;
    logic                         bit_valid;
    logic                         bit_val;
    logic                         noise;
    logic [fskd_pkg::FRAME_W-1:0] shreg;
    logic                         new_bit;

    fskd_period_meter #(
        .CYC_PER_BIT (CYC_PER_BIT),
        .CNT_W       (CNT_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .zc_i         (zc_i),
        .meas_valid_o (meas_valid),
        .period_o     (meas_period)
    );

    fskd_classifier #(
        .SAMPLE_HZ   (SAMPLE_HZ),
        .F_ONE_HZ    (F_ONE_HZ),
        .F_ZERO_HZ   (F_ZERO_HZ),
        .CYC_PER_BIT (CYC_PER_BIT),
        .CNT_W       (CNT_W)
    ) u_class (
        .meas_valid_i (meas_valid),
        .period_i     (meas_period),
        .bit_valid_o  (bit_valid),
        .bit_o        (bit_val),
        .noise_o      (noise)
    );

    fskd_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (bit_valid),
        .bit_i     (bit_val),
        .clear_i   (noise),
        .shreg_o   (shreg),
        .new_bit_o (new_bit)
    );

    fskd_frame_detect u_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .check_i       (new_bit),
        .shreg_i       (shreg),
        .frame_valid_o (frame_valid_o),
        .data_o        (data_o),
        .crc_o         (crc_o),
        .rw_o          (rw_o),
        .ident_err_o   (ident_err_o)
    );

endmodule

// File: rtl/fskd_checker.sv
// fskd_checker: temporal properties of fsk_tag_demod, bound to its
// internal measurement and frame-register nets and to its outputs.
module fskd_checker #(
    parameter longint SAMPLE_HZ   = 2_000_000,
    parameter longint F_ONE_HZ    = 123_200,
    parameter longint F_ZERO_HZ   = 134_200,
    parameter int     CYC_PER_BIT = 16,
    parameter int     CNT_W       = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         meas_valid,
    input logic [CNT_W-1:0] meas_period,
    input logic [127:0] shreg,
    input logic         frame_valid_o,
    input logic [63:0]  data_o,
    input logic [15:0]  crc_o,
    input logic         rw_o,
    input logic         ident_err_o
);
    localparam longint E1  = fskd_pkg::span_samples(SAMPLE_HZ, F_ONE_HZ, CYC_PER_BIT);
    localparam longint E0  = fskd_pkg::span_samples(SAMPLE_HZ, F_ZERO_HZ, CYC_PER_BIT);
    localparam longint TL  = (E1 - E0 + 1) >>> 1;
    localparam logic [CNT_W:0] A1 = (CNT_W+1)'(E1 - TL);
    localparam logic [CNT_W:0] B1 = (CNT_W+1)'(E1 + TL);
    localparam logic [CNT_W:0] A0 = (CNT_W+1)'(E0 - TL);
    localparam logic [CNT_W:0] B0 = (CNT_W+1)'(E0 + TL);

    logic w1, w0;
    assign w1 = ({1'b0, meas_period} > A1) && ({1'b0, meas_period} < B1);
    assign w0 = ({1'b0, meas_period} > A0) && ({1'b0, meas_period} < B0);

    // R3
    one_lands_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid && w1 |=> shreg[127]);

    // R5
    zero_shifts_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid && w0 |=> !shreg[127] && (shreg[126:0] == $past(shreg[127:1])));

    // R4
    noise_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid && !w1 && !w0 |=> shreg == '0);

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> $stable(data_o) && $stable(crc_o) && $stable(rw_o) && $stable(ident_err_o));

    // R6
    sync_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> $past(shreg[22:0]) == 23'h7E0000);

    // R7
    fields_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> data_o == $past(shreg[87:24]) && crc_o == $past(shreg[103:88]) && rw_o == $past(shreg[111]));

    // R8
    ident_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident_err_o |-> rw_o);

endmodule

bind fsk_tag_demod fskd_checker #(
    .SAMPLE_HZ   (SAMPLE_HZ),
    .F_ONE_HZ    (F_ONE_HZ),
    .F_ZERO_HZ   (F_ZERO_HZ),
    .CYC_PER_BIT (CYC_PER_BIT),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .meas_valid    (meas_valid),
    .meas_period   (meas_period),
    .shreg         (shreg),
    .frame_valid_o (frame_valid_o),
    .data_o        (data_o),
    .crc_o         (crc_o),
    .rw_o          (rw_o),
    .ident_err_o   (ident_err_o)
);

// File: tb/fsk_tag_demod_bench.sv
// Scoreboard bench: the driver pushes each frame it expects to be accepted,
// the monitor pops and compares on every strobe.
module fsk_tag_demod_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 198000;
    localparam int  LEN_ONE    = 16;   // 16 cycles x 16 samples = 256 -> bit 1
    localparam int  LEN_ZERO   = 15;   // 16 cycles x 15 samples = 240 -> bit 0
    localparam int  LEN_NOISE  = 25;   // 400 samples -> noise

    typedef struct packed {
        logic [63:0] d;
        logic [15:0] c;
        logic        rw;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        zc_i;
    logic        frame_valid_o;
    logic [63:0] data_o;
    logic [15:0] crc_o;
    logic        rw_o;
    logic        ident_err_o;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_seen = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tag_demod u_fsk_tag_demod (
        .clk           (clk),
        .rst_n         (rst_n),
        .zc_i          (zc_i),
        .frame_valid_o (frame_valid_o),
        .data_o        (data_o),
        .crc_o         (crc_o),
        .rw_o          (rw_o),
        .ident_err_o   (ident_err_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sixteen carrier cycles of the given length, low half then high half.
    task automatic send_group(input int len);
        for (int c = 0; c < 16; c++) begin
            zc_i = 1'b0;
            repeat (len - len/2) @(negedge clk);
            zc_i = 1'b1;
            repeat (len/2) @(negedge clk);
        end
    endtask

    // Frame image: sync, leading byte copied to trailing byte, fields.
    function automatic logic [127:0] build(input logic [63:0] d, input logic [15:0] c,
                                           input logic rw, input logic [14:0] id,
                                           input logic top);
        logic [127:0] f;
        f = '0;
        f[22:17]   = 6'h3F;
        f[23]      = rw;
        f[87:24]   = d;
        f[103:88]  = c;
        f[111:104] = f[23:16];
        f[126:112] = id;
        f[127]     = top;
        return f;
    endfunction

    task automatic send_bits(input logic [127:0] f, input int n);
        for (int i = 0; i < n; i++)
            send_group(f[i] ? LEN_ONE : LEN_ZERO);
    endtask

    task automatic expect_frame(input logic [63:0] d, input logic [15:0] c,
                                input logic rw, input logic [14:0] id);
        exp_t e;
        e.d = d; e.c = c; e.rw = rw; e.err = rw && (id != d[14:0]);
        q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare each strobe against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && frame_valid_o === 1'b1) begin
                n_seen++;
                if (q.size() == 0) begin
                    check(1'b0, "R6 unexpected frame", data_o, 64'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(data_o == e.d, "R7 data", data_o, e.d);
                    check(crc_o == e.c, "R7 crc", {48'h0, crc_o}, {48'h0, e.c});
                    check(rw_o == e.rw, "R7 rw", {63'h0, rw_o}, {63'h0, e.rw});
                    check(ident_err_o == e.err, "R8 ident", {63'h0, ident_err_o}, {63'h0, e.err});
                end
                @(negedge clk);
                check(frame_valid_o == 1'b0, "R9 strobe width", {63'h0, frame_valid_o}, 64'h0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Driver.
    initial begin
        logic [127:0] fa, fb, fc, fd, fe;
        rst_n = 1'b0;
        zc_i  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(frame_valid_o == 1'b0, "R10 strobe", {63'h0, frame_valid_o}, 64'h0);
        check(data_o == 64'h0, "R10 data", data_o, 64'h0);
        check(crc_o == 16'h0, "R10 crc", {48'h0, crc_o}, 64'h0);
        check(rw_o == 1'b0 && ident_err_o == 1'b0, "R10 flags",
              {62'h0, rw_o, ident_err_o}, 64'h0);

        // R1 R2 R3 R5 R6 R7: rewritable frame, ident matches
        fa = build(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1'b1, 15'h4DEF, 1'b0);
        send_group(LEN_NOISE);
        expect_frame(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1'b1, 15'h4DEF);
        send_bits(fa, 128);

        // R7 R8: read-only frame, ident ignored
        fb = build(64'hFEDC_BA98_7654_3210, 16'h1234, 1'b0, 15'h1111, 1'b1);
        send_group(LEN_NOISE);
        expect_frame(64'hFEDC_BA98_7654_3210, 16'h1234, 1'b0, 15'h1111);
        send_bits(fb, 128);

        // R8: rewritable frame with ident mismatch
        fc = build(64'h0000_00FF_AA55_0F0F, 16'hC0DE, 1'b1, 15'h0F0E, 1'b0);
        send_group(LEN_NOISE);
        expect_frame(64'h0000_00FF_AA55_0F0F, 16'hC0DE, 1'b1, 15'h0F0E);
        send_bits(fc, 128);

        // R6: trailing byte differs from leading byte -> no frame
        fd = fa;
        fd[104] = 1'b1;
        send_group(LEN_NOISE);
        send_bits(fd, 128);

        // R2 R4: long silence before the last bit saturates -> noise clears
        fe = build(64'h1111_2222_3333_4444, 16'h5555, 1'b0, 15'h0, 1'b1);
        send_group(LEN_NOISE);
        send_bits(fe, 127);
        zc_i = 1'b0;
        repeat (512) @(negedge clk);
        send_group(LEN_ONE);
        send_group(LEN_NOISE);
        repeat (10) @(negedge clk);

        // R6: exactly the three good frames were published
        check(q.size() == 0, "R6 missing frame", 64'(q.size()), 64'h0);
        check(n_seen == 3, "R6 frame count", 64'(n_seen), 64'd3);
        // R9: outputs still hold the last accepted frame
        check(data_o == 64'h0000_00FF_AA55_0F0F, "R9 hold data", data_o, 64'h0000_00FF_AA55_0F0F);
        check(crc_o == 16'hC0DE && rw_o && ident_err_o, "R9 hold fields",
              {46'h0, crc_o, rw_o, ident_err_o}, {46'h0, 16'hC0DE, 1'b1, 1'b1});
        finish_run();
    end

endmodule